// File: doc/BRIEF.md
# Coin Accumulator with Purchase Threshold

This block keeps the running credit of a coin-operated vending front end. Three coin-type lines, one each for a 5-cent, 10-cent and 25-cent coin, say which coin the acceptor has just recognised. A separate strobe pulses once for each coin. On each pulse, the value of the flagged coin is added to a stored total, and the sum is written back. A credit flag rises once the total reaches 30 cents. The flag stays high until the active-low reset clears the total.

The strobe and the coin-type lines come from the mechanical acceptor, so they are asynchronous. They pass through a synchroniser first. An edge detector then turns each strobe pulse into a single add, however many clock cycles the pulse lasts. The interface has no valid/ready handshake. The acceptor cannot be stalled, so there is no back-pressure path: every clean pulse is consumed. The coin-type lines must stay stable from the strobe's rise until at least three clock cycles after it falls. The total is kept in cents in a saturating register.

Top module: `coin_totalizer`

## Requirements
- R1: While rst_n is low, and right after it is released, total_cents is 0 and credit_ok is 0.
- R2: A pulse with exactly one type line high adds that coin's value to total_cents: coin_nickel adds 5, coin_dime adds 10 and coin_quarter adds 25.
- R3: Each strobe pulse adds exactly once, whether it lasts 1 cycle or many.
- R4: total_cents changes only on the third rising clock edge after coin_strobe is first sampled high. It never changes at any other time, except through reset.
- R5: A strobe pulse with no type line high, or with two or more high, leaves total_cents unchanged.
- R6: total_cents saturates at 2^TOTAL_W-1 (127 at the default width of 7) and never wraps.
- R7: credit_ok is high exactly when total_cents is 30 or more. Once high, it stays high until reset.
- R8: Changes on the type lines while coin_strobe stays low have no effect on total_cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the total |
| coin_strobe | input | 1 | Asynchronous pulse, one per inserted coin |
| coin_nickel | input | 1 | Coin is worth 5 cents |
| coin_dime | input | 1 | Coin is worth 10 cents |
| coin_quarter | input | 1 | Coin is worth 25 cents |
| total_cents | output | TOTAL_W | Accumulated credit in cents |
| credit_ok | output | 1 | Total has reached the 30-cent threshold |

## Verification
The main function is driven with several coin sequences, and each one separates a different failure:
- Mixed denominations catch a wrong coin value.
- Strobes 1, 3 and 8 cycles wide catch double counting.
- Pulses with no type line or two type lines high catch a missing one-hot check.
- Runs that stop at 25 and then at 30 cents pin down the exact threshold edge.
- A run of quarters past 127 shows whether the register saturates or wraps.

One coin is also timed edge by edge, to fix the update latency.

// File: rtl/coin_pkg.sv
package coin_pkg;
  localparam int unsigned NICKEL_CENTS  = 5;
  localparam int unsigned DIME_CENTS    = 10;
  localparam int unsigned QUARTER_CENTS = 25;
  localparam int unsigned CREDIT_CENTS  = 30;

  typedef struct packed {
    logic quarter;
    logic dime;
    logic nickel;
  } coin_sel_t;
endpackage

// File: rtl/coin_strobe_sync.sv
module coin_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_async,
  input  coin_pkg::coin_sel_t sel_async,
  output logic              strobe_rise,
  output coin_pkg::coin_sel_t sel_sync
);
  localparam int unsigned PW = $bits(coin_pkg::coin_sel_t) + 1;

  logic [PW-1:0] pipe [STAGES];
  logic          strobe_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      strobe_prev <= 1'b0;
    end else begin
      pipe[0] <= {strobe_async, sel_async};
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      strobe_prev <= pipe[STAGES-1][PW-1];
    end
  end

  assign strobe_rise = pipe[STAGES-1][PW-1] & ~strobe_prev;
  assign sel_sync    = coin_pkg::coin_sel_t'(pipe[STAGES-1][PW-2:0]);

  // R3: a detected rise is never two cycles long
  p_single_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);
endmodule

// File: rtl/coin_value_decode.sv
module coin_value_decode #(
  parameter int unsigned VAL_W = 7
) (
  input  coin_pkg::coin_sel_t sel,
  output logic [VAL_W-1:0]    value,
  output logic                valid
);
  always_comb begin
    valid = 1'b1;
    unique case (sel)
      3'b001:  value = VAL_W'(coin_pkg::NICKEL_CENTS);
      3'b010:  value = VAL_W'(coin_pkg::DIME_CENTS);
      3'b100:  value = VAL_W'(coin_pkg::QUARTER_CENTS);
      default: begin
        value = '0;
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/coin_total_reg.sv
module coin_total_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] total
);
  localparam logic [W-1:0] MAX = '1;

  logic [W:0] sum;
  assign sum = {1'b0, total} + {1'b0, add_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total <= '0;
    else if (add_en) total <= sum[W] ? MAX : sum[W-1:0];
  end

  // R4: nothing but an accepted coin moves the total
  p_only_on_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(total));
  // R6: the total never wraps to a smaller value
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> total >= $past(total));
  // R2: a coin that fits is added exactly
  p_add_amount_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !sum[W]) |=> {1'b0, total} == $past(sum));
endmodule

// File: rtl/coin_totalizer.sv
module coin_totalizer #(
  parameter int unsigned TOTAL_W     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coin_strobe,
  input  logic               coin_nickel,
  input  logic               coin_dime,
  input  logic               coin_quarter,
  output logic [TOTAL_W-1:0] total_cents,
  output logic               credit_ok
);
  localparam logic [TOTAL_W-1:0] THRESH = TOTAL_W'(coin_pkg::CREDIT_CENTS);

  coin_pkg::coin_sel_t sel_in, sel_s;
  logic               rise, val_ok, add_en;
  logic [TOTAL_W-1:0] coin_val;

  assign sel_in = '{quarter: coin_quarter, dime: coin_dime, nickel: coin_nickel};

  coin_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_async(coin_strobe), .sel_async(sel_in),
    .strobe_rise(rise), .sel_sync(sel_s));

  coin_value_decode #(.VAL_W(TOTAL_W)) u_dec (
    .sel(sel_s), .value(coin_val), .valid(val_ok));

  assign add_en = rise & val_ok;

  coin_total_reg #(.W(TOTAL_W)) u_total (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_val(coin_val),
    .total(total_cents));

  assign credit_ok = (total_cents >= THRESH);

  initial assert (TOTAL_W >= 6) else $error("TOTAL_W too small for 55 cents");

  // R7: credit, once earned, is held until reset
  p_credit_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ok |=> credit_ok);
endmodule

// File: tb/test_coin_totalizer.sv
module test_coin_totalizer;
  localparam int MAXV = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coin_strobe = 1'b0, coin_nickel = 1'b0, coin_dime = 1'b0, coin_quarter = 1'b0;
  logic [6:0] total_cents;
  logic credit_ok;

  int checks = 0, failures = 0;
  int exp_total = 0;
  int exp_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coin_totalizer i_coin_totalizer (
    .clk(clk), .rst_n(rst_n), .coin_strobe(coin_strobe), .coin_nickel(coin_nickel),
    .coin_dime(coin_dime), .coin_quarter(coin_quarter),
    .total_cents(total_cents), .credit_ok(credit_ok));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_val(int v);
    int nv;
    nv = (exp_total + v > MAXV) ? MAXV : exp_total + v;
    if (nv != exp_total) exp_q.push_back(nv);
    exp_total = nv;
  endtask

  task automatic settle_check(string req);
    check({req, " total"}, int'(total_cents), exp_total);
    check("R7 credit", int'(credit_ok), (exp_total >= 30) ? 1 : 0);
  endtask

  // driver: n,d,q select lines, width in cycles, value expected to be added
  task automatic insert(bit n, bit d, bit q, int width, int v, string req);
    @(negedge clk);
    coin_nickel = n; coin_dime = d; coin_quarter = q;
    expect_val(v);
    coin_strobe = 1'b1;
    repeat (width) @(negedge clk);
    coin_strobe = 1'b0;
    repeat (5) @(negedge clk);
    coin_nickel = 1'b0; coin_dime = 1'b0; coin_quarter = 1'b0;
    @(negedge clk);
    settle_check(req);
  endtask

  // monitor: every change of the total must match the next queued value
  logic [6:0] last_total = '0;
  always @(negedge clk) begin
    if (mon_en && total_cents != last_total) begin
      if (exp_q.size() == 0) check("R4 unexpected change", int'(total_cents), int'(last_total));
      else check("R2 scoreboard", int'(total_cents), exp_q.pop_front());
      last_total = total_cents;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset total", int'(total_cents), 0);
    check("R1 reset credit", int'(credit_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    check("R1 after release", int'(total_cents), 0);

    insert(1, 0, 0, 1, 5, "R2 nickel");
    insert(0, 1, 0, 3, 10, "R3 dime wide");
    insert(0, 0, 0, 2, 0, "R5 no type");
    insert(1, 1, 0, 2, 0, "R5 two types");
    insert(1, 0, 0, 8, 5, "R3 nickel long");
    insert(1, 0, 0, 1, 5, "R7 at 25");
    check("R7 below threshold", int'(credit_ok), 0);

    // R8: type lines toggle without strobe
    @(negedge clk);
    coin_quarter = 1'b1;
    repeat (4) @(negedge clk);
    coin_quarter = 1'b0; coin_dime = 1'b1;
    repeat (4) @(negedge clk);
    coin_dime = 1'b0;
    repeat (2) @(negedge clk);
    settle_check("R8 no strobe");

    // R4: latency check with a nickel reaching exactly 30
    @(negedge clk);
    coin_nickel = 1'b1; coin_strobe = 1'b1;
    expect_val(5);
    @(negedge clk);
    @(negedge clk);
    check("R4 before third edge", int'(total_cents), 25);
    @(negedge clk);
    check("R4 at third edge", int'(total_cents), 30);
    check("R7 at threshold", int'(credit_ok), 1);
    coin_strobe = 1'b0;
    repeat (5) @(negedge clk);
    coin_nickel = 1'b0;
    @(negedge clk);

    // R1: reset mid-run
    exp_q.push_back(0);
    exp_total = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset total", int'(total_cents), 0);
    check("R1 mid reset credit", int'(credit_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);

    insert(0, 0, 1, 2, 25, "R2 quarter");
    insert(1, 0, 1, 1, 0, "R5 nickel+quarter");
    insert(0, 1, 0, 1, 10, "R2 dime to 35");
    for (int k = 0; k < 3; k++) insert(0, 0, 1, 1, 25, "R2 quarters");
    insert(0, 1, 0, 1, 10, "R6 near top");
    insert(0, 0, 1, 1, 25, "R6 saturate");
    check("R6 saturated", int'(total_cents), 127);
    insert(1, 0, 0, 1, 5, "R6 hold max");
    check("R7 still high", int'(credit_ok), 1);

    repeat (3) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule